// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Request Unit

This block sits between the receive/transmit machinery of a serial port and the interrupt and DMA fabric of the chip. It keeps six status flags: transmit buffer empty, receive buffer full, transmission finished, and overrun, parity and framing errors. From those flags it derives four separate interrupt requests, each gated by an enable input. It also reports which pending, enabled source has the highest priority as a 2-bit code with a valid bit.

Two of the flags, transmit-empty and receive-full, also drive DMA request lines. These lines are not gated by the interrupt enables, so a DMA engine can move data while the interrupts stay masked. Each flag clears itself when the DMA engine reports a completed access to the matching data register. Software clears a flag by reading the status word and then writing 0 to a bit it saw as 1. A set event in the same cycle as any clear always leaves the flag set.

Top module: `serial_event_unit`

## Requirements
- R1: After a synchronous active-low reset, all six flags read 0, all four interrupt requests and both DMA requests are 0, and `top_valid` is 0.
- R2: A set strobe raises its flag at the next clock edge. The `flag_bus` bit positions are: 0 transmit-empty, 1 receive-full, 2 transmit-end, 3 overrun, 4 parity, 5 framing.
- R3: `irq_tx_empty` is the transmit-empty flag ANDed with `en_tx_irq`. `irq_rx_full` is the receive-full flag ANDed with `en_rx_irq`. `irq_tx_end` is the transmit-end flag ANDed with `en_tend_irq`.
- R4: `irq_rx_err` is 1 when `en_rx_irq` is 1 and at least one of the overrun, parity or framing flags is 1.
- R5: `dma_tx_req` follows the transmit-empty flag and `dma_rx_req` follows the receive-full flag, whatever the enables. The error and transmit-end flags never raise either DMA request.
- R6: A `dma_tx_wr_done` pulse clears transmit-empty at the next edge. A `dma_rx_rd_done` pulse clears receive-full at the next edge. Neither pulse changes any other flag.
- R7: A software write (`sw_wr`) clears a flag only where its `sw_wdata` bit is 0 and the last `sw_rd` strobe saw that flag as 1. A write without a prior read, or a write of 1, leaves the flag set.
- R8: When a set strobe and a clear (by DMA or by software) hit the same flag in the same cycle, the flag is 1 after the edge.
- R9: `top_src` gives the highest-priority enabled pending request, using the codes 0 receive error, 1 receive full, 2 transmit empty, 3 transmit end (0 is the highest priority). `top_valid` is 1 exactly when any interrupt request is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_tx_empty | input | 1 | Transmit buffer handed to shifter |
| set_rx_full | input | 1 | Received character stored |
| set_tx_end | input | 1 | Transmission finished |
| set_overrun | input | 1 | Overrun detected |
| set_parity | input | 1 | Parity error detected |
| set_framing | input | 1 | Framing error detected |
| dma_tx_wr_done | input | 1 | DMA write of transmit data register completed |
| dma_rx_rd_done | input | 1 | DMA read of receive data register completed |
| sw_rd | input | 1 | Software status read strobe |
| sw_wr | input | 1 | Software status write strobe |
| sw_wdata | input | 6 | Software write data, 0 requests clear |
| en_tx_irq | input | 1 | Transmit-empty interrupt enable |
| en_rx_irq | input | 1 | Receive-full and receive-error interrupt enable |
| en_tend_irq | input | 1 | Transmit-end interrupt enable |
| flag_bus | output | 6 | Current flags |
| irq_rx_err | output | 1 | Receive error request |
| irq_rx_full | output | 1 | Receive full request |
| irq_tx_empty | output | 1 | Transmit empty request |
| irq_tx_end | output | 1 | Transmit end request |
| dma_tx_req | output | 1 | DMA transmit request |
| dma_rx_req | output | 1 | DMA receive request |
| top_src | output | 2 | Highest-priority pending source code |
| top_valid | output | 1 | Any request pending |

## Verification
Two functions can fall in the same cycle: a flag's set strobe and its clear. The clear can come from a DMA completion pulse or from a software write of 0 after a read. The bench provokes this by driving `set_tx_empty` together with `dma_tx_wr_done`, and `set_overrun` together with an armed software clear. It then judges `flag_bus` after the edge: the flag must still be 1. Priority resolution is judged while all sources are pending, removing them one at a time and reading `top_src` after each removal.

// File: rtl/serial_event_pkg.sv
// Shared constants for the serial event unit: flag positions and source codes.
package serial_event_pkg;
    localparam int NUM_FLAGS = 6;
    localparam int NUM_SRC   = 4;
    localparam int SRC_W     = $clog2(NUM_SRC);

    localparam int FLG_TXE = 0;
    localparam int FLG_RXF = 1;
    localparam int FLG_TND = 2;
    localparam int FLG_OVR = 3;
    localparam int FLG_PAR = 4;
    localparam int FLG_FRM = 5;

    typedef enum logic [SRC_W-1:0] {
        SRC_RX_ERR  = 2'd0,
        SRC_RX_FULL = 2'd1,
        SRC_TX_EMPT = 2'd2,
        SRC_TX_END  = 2'd3
    } src_code_e;
endpackage

// File: rtl/sev_flag_cell.sv
// One status flag. It is set by a hardware strobe and cleared by a DMA pulse,
// or by a software write of 0 after a read that saw the flag as 1.
// Assumes the strobes are one cycle wide and synchronous to clk. Set wins over clear.
module sev_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic dma_clr_i,
    input  logic sw_rd_i,
    input  logic sw_wr_i,
    input  logic sw_wbit_i,
    output logic flag_o
);
    logic flag_q;
    logic armed_q;
    logic sw_clr;
    logic clr;

    // Clear sources combined; software clear needs a prior read of 1
    always_comb begin
        sw_clr = sw_wr_i && !sw_wbit_i && armed_q;
        clr    = sw_clr || dma_clr_i;
    end

    // Flag register, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    // Remembers whether the last software read saw the flag as 1
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (sw_rd_i)
            armed_q <= flag_q;
        else if (sw_wr_i || dma_clr_i)
            armed_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sev_req_gate.sv
// Builds the interrupt requests from flags and enables, and the DMA requests from flags alone.
// Assumes the flag vector layout given in serial_event_pkg.
module sev_req_gate
    import serial_event_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags_i,
    input  logic                 en_tx_i,
    input  logic                 en_rx_i,
    input  logic                 en_tend_i,
    output logic [NUM_SRC-1:0]   irq_o,
    output logic                 dma_tx_o,
    output logic                 dma_rx_o
);
    logic any_err;

    // Interrupt gating per source, indexed by source code
    always_comb begin
        any_err                     = flags_i[FLG_OVR] | flags_i[FLG_PAR] | flags_i[FLG_FRM];
        irq_o                       = '0;
        irq_o[int'(SRC_RX_ERR)]     = en_rx_i   & any_err;
        irq_o[int'(SRC_RX_FULL)]    = en_rx_i   & flags_i[FLG_RXF];
        irq_o[int'(SRC_TX_EMPT)]    = en_tx_i   & flags_i[FLG_TXE];
        irq_o[int'(SRC_TX_END)]     = en_tend_i & flags_i[FLG_TND];
    end

    // DMA requests ignore the interrupt enables
    always_comb begin
        dma_tx_o = flags_i[FLG_TXE];
        dma_rx_o = flags_i[FLG_RXF];
    end
endmodule

// File: rtl/sev_prio_enc.sv
// Fixed-priority encoder: the lowest index wins. Assumes N >= 2.
module sev_prio_enc #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    output logic [W-1:0] idx_o,
    output logic         valid_o
);
    // Scan from lowest to highest priority so the highest priority is written last
    always_comb begin
        idx_o   = '0;
        valid_o = |req_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i])
                idx_o = W'(i);
        end
    end
endmodule

// File: rtl/serial_event_unit.sv
// Status flags, interrupt and DMA requests for a serial port.
// Holds six flags and derives four gated interrupt requests, two DMA requests
// and the code of the highest-priority pending source. All strobe inputs are
// synchronous single-cycle pulses.
module serial_event_unit
    import serial_event_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_tx_empty,
    input  logic                 set_rx_full,
    input  logic                 set_tx_end,
    input  logic                 set_overrun,
    input  logic                 set_parity,
    input  logic                 set_framing,
    input  logic                 dma_tx_wr_done,
    input  logic                 dma_rx_rd_done,
    input  logic                 sw_rd,
    input  logic                 sw_wr,
    input  logic [NUM_FLAGS-1:0] sw_wdata,
    input  logic                 en_tx_irq,
    input  logic                 en_rx_irq,
    input  logic                 en_tend_irq,
    output logic [NUM_FLAGS-1:0] flag_bus,
    output logic                 irq_rx_err,
    output logic                 irq_rx_full,
    output logic                 irq_tx_empty,
    output logic                 irq_tx_end,
    output logic                 dma_tx_req,
    output logic                 dma_rx_req,
    output logic [SRC_W-1:0]     top_src,
    output logic                 top_valid
);
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] dma_clr_vec;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_SRC-1:0]   irq_vec;

    // Gather the set strobes and DMA clears in flag-position order
    always_comb begin
        set_vec              = '0;
        set_vec[FLG_TXE]     = set_tx_empty;
        set_vec[FLG_RXF]     = set_rx_full;
        set_vec[FLG_TND]     = set_tx_end;
        set_vec[FLG_OVR]     = set_overrun;
        set_vec[FLG_PAR]     = set_parity;
        set_vec[FLG_FRM]     = set_framing;
        dma_clr_vec          = '0;
        dma_clr_vec[FLG_TXE] = dma_tx_wr_done;
        dma_clr_vec[FLG_RXF] = dma_rx_rd_done;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sev_flag_cell i_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_vec[g]),
            .dma_clr_i (dma_clr_vec[g]),
            .sw_rd_i   (sw_rd),
            .sw_wr_i   (sw_wr),
            .sw_wbit_i (sw_wdata[g]),
            .flag_o    (flags[g])
        );
    end

    sev_req_gate i_gate (
        .flags_i   (flags),
        .en_tx_i   (en_tx_irq),
        .en_rx_i   (en_rx_irq),
        .en_tend_i (en_tend_irq),
        .irq_o     (irq_vec),
        .dma_tx_o  (dma_tx_req),
        .dma_rx_o  (dma_rx_req)
    );

    sev_prio_enc #(.N(NUM_SRC)) i_prio (
        .req_i   (irq_vec),
        .idx_o   (top_src),
        .valid_o (top_valid)
    );

    // Drive the individual request outputs and the status view
    always_comb begin
        flag_bus     = flags;
        irq_rx_err   = irq_vec[int'(SRC_RX_ERR)];
        irq_rx_full  = irq_vec[int'(SRC_RX_FULL)];
        irq_tx_empty = irq_vec[int'(SRC_TX_EMPT)];
        irq_tx_end   = irq_vec[int'(SRC_TX_END)];
    end
endmodule

// File: rtl/serial_event_unit_chk.sv
// Protocol checker for serial_event_unit, attached by bind.
module serial_event_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       set_tx_empty,
    input logic       set_overrun,
    input logic       dma_tx_wr_done,
    input logic       sw_wr,
    input logic [5:0] sw_wdata,
    input logic [5:0] flag_bus,
    input logic       irq_rx_err,
    input logic       irq_rx_full,
    input logic       irq_tx_empty,
    input logic       irq_tx_end,
    input logic       dma_tx_req,
    input logic       dma_rx_req,
    input logic [1:0] top_src,
    input logic       top_valid
);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_tx_empty |=> flag_bus[0]);

    assert_dma_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_tx_wr_done && !set_tx_empty) |=> !flag_bus[0]);

    assert_dma_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_tx_req) |-> $past(set_tx_empty));

    assert_err_no_dma_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_tx_req || dma_rx_req) |-> (flag_bus[0] || flag_bus[1]));

    assert_sw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_bus[3]) |-> $past(sw_wr && !sw_wdata[3]));

    assert_err_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_err |-> (top_valid && top_src == 2'd0));

    assert_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid == (irq_rx_err || irq_rx_full || irq_tx_empty || irq_tx_end));

    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_overrun |=> flag_bus[3]);
endmodule

bind serial_event_unit serial_event_unit_chk i_chk (.*);

// File: tb/test_serial_event_unit.sv
module test_serial_event_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_tx_empty = 0, set_rx_full = 0, set_tx_end = 0;
    logic       set_overrun = 0, set_parity = 0, set_framing = 0;
    logic       dma_tx_wr_done = 0, dma_rx_rd_done = 0;
    logic       sw_rd = 0, sw_wr = 0;
    logic [5:0] sw_wdata = '1;
    logic       en_tx_irq = 0, en_rx_irq = 0, en_tend_irq = 0;
    logic [5:0] flag_bus;
    logic       irq_rx_err, irq_rx_full, irq_tx_empty, irq_tx_end;
    logic       dma_tx_req, dma_rx_req;
    logic [1:0] top_src;
    logic       top_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    serial_event_unit i_serial_event_unit (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: inputs set after a falling edge, outputs read at the next falling edge
    task automatic tick();
        @(negedge clk);
        {set_tx_empty, set_rx_full, set_tx_end, set_overrun, set_parity, set_framing} = '0;
        {dma_tx_wr_done, dma_rx_rd_done, sw_rd, sw_wr} = '0;
        sw_wdata = '1;
    endtask

    task automatic sw_clear(input logic [5:0] mask);
        sw_rd = 1; tick();
        sw_wr = 1; sw_wdata = ~mask; tick();
    endtask

    task automatic t_reset();
        chk("R1 flags", flag_bus, 0);
        chk("R1 irqs", {irq_rx_err, irq_rx_full, irq_tx_empty, irq_tx_end}, 0);
        chk("R1 dma", {dma_tx_req, dma_rx_req}, 0);
        chk("R1 valid", top_valid, 0);
    endtask

    task automatic t_set_gate();
        set_tx_empty = 1; tick();
        chk("R2 txe bit0", flag_bus, 6'h01);
        chk("R3 masked txe", irq_tx_empty, 0);
        chk("R5 dma tx masked irq", dma_tx_req, 1);
        chk("R9 none valid", top_valid, 0);
        en_tx_irq = 1; tick();
        chk("R3 txe irq", irq_tx_empty, 1);
        chk("R9 txe code", {top_valid, top_src}, 3'b110);
        set_rx_full = 1; tick();
        chk("R2 rxf bit1", flag_bus, 6'h03);
        chk("R3 rxf masked", irq_rx_full, 0);
        chk("R5 dma rx", dma_rx_req, 1);
    endtask

    task automatic t_dma_clear();
        dma_tx_wr_done = 1; tick();
        chk("R6 txe cleared", flag_bus, 6'h02);
        chk("R6 dma tx drop", dma_tx_req, 0);
        dma_rx_rd_done = 1; tick();
        chk("R6 rxf cleared", flag_bus, 6'h00);
        set_tx_end = 1; set_framing = 1; tick();
        dma_tx_wr_done = 1; dma_rx_rd_done = 1; tick();
        chk("R6 others kept", flag_bus, 6'h24);
        sw_clear(6'h24);
        chk("R7 cleared pair", flag_bus, 0);
    endtask

    task automatic t_errors();
        en_rx_irq = 1; en_tend_irq = 1;
        set_parity = 1; tick();
        chk("R4 parity irq", irq_rx_err, 1);
        chk("R5 no dma err", {dma_tx_req, dma_rx_req}, 0);
        set_tx_end = 1; tick();
        chk("R5 no dma tend", {dma_tx_req, dma_rx_req}, 0);
        chk("R3 tend irq", irq_tx_end, 1);
        en_rx_irq = 0; tick();
        chk("R4 masked err", irq_rx_err, 0);
        chk("R9 tend code", {top_valid, top_src}, 3'b111);
        sw_clear(6'h14);
        en_rx_irq = 1;
        set_overrun = 1; tick();
        chk("R4 overrun irq", irq_rx_err, 1);
        sw_clear(6'h08);
        chk("R4 err gone", irq_rx_err, 0);
    endtask

    task automatic t_priority();
        en_tx_irq = 1; en_rx_irq = 1; en_tend_irq = 1;
        set_tx_empty = 1; set_rx_full = 1; set_tx_end = 1; set_overrun = 1; tick();
        chk("R9 err first", {top_valid, top_src}, 3'b100);
        sw_clear(6'h08);
        chk("R9 rxf next", {top_valid, top_src}, 3'b101);
        dma_rx_rd_done = 1; tick();
        chk("R9 txe next", {top_valid, top_src}, 3'b110);
        dma_tx_wr_done = 1; tick();
        chk("R9 tend last", {top_valid, top_src}, 3'b111);
        en_tend_irq = 0; tick();
        chk("R9 masked none", top_valid, 0);
        sw_clear(6'h04);
    endtask

    task automatic t_sw_clear();
        set_framing = 1; tick();
        sw_wr = 1; sw_wdata = 6'h00; tick();
        chk("R7 no prior read", flag_bus, 6'h20);
        sw_rd = 1; tick();
        sw_wr = 1; sw_wdata = 6'h3F; tick();
        chk("R7 write one keeps", flag_bus, 6'h20);
        sw_clear(6'h20);
        chk("R7 read then zero", flag_bus, 6'h00);
    endtask

    task automatic t_collision();
        set_tx_empty = 1; tick();
        set_tx_empty = 1; dma_tx_wr_done = 1; tick();
        chk("R8 set beats dma", flag_bus[0], 1);
        set_overrun = 1; tick();
        sw_rd = 1; tick();
        sw_wr = 1; sw_wdata = 6'h00; set_overrun = 1; tick();
        chk("R8 set beats sw", flag_bus[3], 1);
        sw_clear(6'h09);
        chk("R8 clear after", flag_bus, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        tick();
        t_reset();
        t_set_gate();
        t_dma_clear();
        t_errors();
        t_priority();
        t_sw_clear();
        t_collision();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule